// File: doc/BRIEF.md
# Blocking Write-Back Data Cache Controller

This block is a direct-mapped data cache that sits between a processor load/store port and a block-wide memory port. It holds 1024 lines of four 32-bit words, 16 KB in total. Every line carries a tag, a valid flag and a dirty flag. Writes land in the cache only. Memory is updated when a modified line is displaced.

The processor presents one word access at a time. The controller accepts it in its idle state and compares the stored tag. A hit finishes in the following cycle. A miss stalls the processor. If the displaced line is modified, the controller first sends that line to memory as a single 128-bit write. It then fetches the new block as a single 128-bit read and completes the access as a hit. A write that misses fetches the block first, merges the word and marks the line modified.

The memory port uses a valid/ready handshake. The controller holds its request steady until memory signals completion, which may take any number of cycles.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset, `cpu_ready_o` and `mem_valid_o` are low and every line is invalid. The first access to any line after reset is a miss, even if the line was filled before the reset.
- R2: The address splits as follows. Bits 31:14 are the tag and bits 13:4 are the line index. Bits 3:2 pick the word, where word k sits at bits 32k+31:32k of a block. Bits 1:0 are ignored. Memory addresses are always block aligned (bits 3:0 zero).
- R3: A read hit raises `cpu_ready_o` one cycle after the request is accepted. In that cycle it returns the stored word and makes no memory transfer.
- R4: A write hit replaces the addressed word in the cache, makes no memory transfer and marks the line modified.
- R5: A miss to an invalid or unmodified line makes exactly one memory read of the requested block and fills the line. `cpu_ready_o` rises in the cycle after that read completes.
- R6: A miss to a modified line first writes the old block to memory at its own address, with its current contents (`mem_we_o` high). Only then does it read the new block.
- R7: A write miss fetches the block, merges the written word into it and leaves the line modified. The other three words keep the fetched values.
- R8: The controller is blocking. `cpu_ready_o` is a one-cycle pulse that stays low until the whole access is done. A memory request keeps `mem_valid_o`, `mem_we_o` and `mem_addr_o` steady until `mem_ready_i`. With memory answering L cycles after a request appears, the request-to-ready time is L+3 cycles for a clean miss and 2L+5 cycles for a modified miss.
- R9: Two addresses with the same index and different tags displace each other. Addresses with different indices stay resident together.
- R10: A freshly fetched line that has not been written is unmodified, so displacing it causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor request present (sampled in idle) |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 32 | Byte address |
| cpu_wdata_i | input | 32 | Write word |
| cpu_rdata_o | output | 32 | Read word, valid while `cpu_ready_o` is high on a read |
| cpu_ready_o | output | 1 | Access complete pulse |
| mem_valid_o | output | 1 | Memory request present |
| mem_we_o | output | 1 | 1 = block write, 0 = block read |
| mem_addr_o | output | 32 | Block-aligned memory address |
| mem_wdata_o | output | 128 | Block written to memory |
| mem_rdata_i | input | 128 | Block read from memory |
| mem_ready_i | input | 1 | Memory transfer complete |

## Verification
The hardest state to reach is a displacement of a modified line, followed back to back by a refill, while memory is slow. It takes a write hit to dirty a line, then a read of another address with the same index but a different tag. The bench then checks the order of transfers, the merged block that was written out, and the exact stall length. A write miss later displaced the same way shows that the merge happened. Reading the written-back block again proves the data reached memory, and a second reset shows the lines are forgotten.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB,
    ST_ALLOC
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int LINES = 1024,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_i,
  input  logic             mark_dirty_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // state bits reset; tags need none since valid gates them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_i) begin
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dirty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= tag_i;
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int LINES  = 1024,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEL_W  = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [LINE_W-1:0] line_o,
  output logic [WORD_W-1:0] word_o
);
  logic [LINE_W-1:0] line_q [LINES];
  logic [WORD_W-1:0] lanes [WORDS];

  always_ff @(posedge clk_i) begin
    if (fill_i)    line_q[idx_i] <= fill_data_i;
    else if (wr_i) line_q[idx_i][sel_i*WORD_W +: WORD_W] <= wdata_i;
  end

  assign line_o = line_q[idx_i];

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign lanes[g] = line_o[g*WORD_W +: WORD_W];
  end

  assign word_o = lanes[sel_i];
endmodule

// File: rtl/cache_fsm.sv
module cache_fsm
  import cache_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         hit_i,
  input  logic         victim_dirty_i,
  input  logic         mem_ready_i,
  output cache_state_e state_o
);
  cache_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = ST_CMP;
      ST_CMP: begin
        if (hit_i)               state_d = ST_IDLE;
        else if (victim_dirty_i) state_d = ST_WB;
        else                     state_d = ST_ALLOC;
      end
      ST_WB:    if (mem_ready_i) state_d = ST_ALLOC;
      ST_ALLOC: if (mem_ready_i) state_d = ST_CMP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 1024,
  localparam int LINE_W     = WORD_W * WORDS,
  localparam int BYTE_OFF_W = $clog2(WORD_W / 8),
  localparam int SEL_W      = $clog2(WORDS),
  localparam int OFF_W      = SEL_W + BYTE_OFF_W,
  localparam int IDX_W      = $clog2(LINES),
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W,
  localparam int REQ_W      = ADDR_W - BYTE_OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  output logic [WORD_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  cache_state_e state;

  logic [REQ_W-1:0]  req_addr_q;
  logic              req_we_q;
  logic [WORD_W-1:0] req_wdata_q;

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  logic [SEL_W-1:0] req_sel;

  logic [TAG_W-1:0] line_tag;
  logic             line_valid, line_dirty;
  logic             accept, hit, fill, word_wr;
  logic [LINE_W-1:0] line_data;

  // byte lanes within a word are not used: aligned word accesses only
  logic unused_byte_off;
  assign unused_byte_off = ^cpu_addr_i[BYTE_OFF_W-1:0];

  assign accept = (state == ST_IDLE) && cpu_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_wdata_q <= '0;
    end else if (accept) begin
      req_addr_q  <= cpu_addr_i[ADDR_W-1:BYTE_OFF_W];
      req_we_q    <= cpu_we_i;
      req_wdata_q <= cpu_wdata_i;
    end
  end

  assign req_sel = req_addr_q[SEL_W-1:0];
  assign req_idx = req_addr_q[SEL_W +: IDX_W];
  assign req_tag = req_addr_q[REQ_W-1 -: TAG_W];

  assign hit     = line_valid && (line_tag == req_tag);
  assign fill    = (state == ST_ALLOC) && mem_ready_i;
  assign word_wr = (state == ST_CMP) && hit && req_we_q;

  cache_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (cpu_valid_i),
    .hit_i          (hit),
    .victim_dirty_i (line_valid && line_dirty),
    .mem_ready_i    (mem_ready_i),
    .state_o        (state)
  );

  cache_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_i        (req_idx),
    .tag_i        (req_tag),
    .fill_i       (fill),
    .mark_dirty_i (word_wr),
    .tag_o        (line_tag),
    .valid_o      (line_valid),
    .dirty_o      (line_dirty)
  );

  cache_data_store #(
    .LINES  (LINES),
    .WORD_W (WORD_W),
    .WORDS  (WORDS)
  ) u_data (
    .clk_i       (clk_i),
    .idx_i       (req_idx),
    .fill_i      (fill),
    .fill_data_i (mem_rdata_i),
    .wr_i        (word_wr),
    .sel_i       (req_sel),
    .wdata_i     (req_wdata_q),
    .line_o      (line_data),
    .word_o      (cpu_rdata_o)
  );

  assign cpu_ready_o = (state == ST_CMP) && hit;
  assign mem_valid_o = (state == ST_WB) || (state == ST_ALLOC);
  assign mem_we_o    = (state == ST_WB);
  assign mem_wdata_o = line_data;

  always_comb begin
    mem_addr_o = '0;
    if (state == ST_WB)         mem_addr_o = {line_tag, req_idx, {OFF_W{1'b0}}};
    else if (state == ST_ALLOC) mem_addr_o = {req_tag, req_idx, {OFF_W{1'b0}}};
  end
endmodule

// File: rtl/wb_cache_ctrl_chk.sv
module wb_cache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_ready_o,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ready_i
);
  assert_block_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[OFF_W-1:0] == '0));

  assert_hit_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |-> !mem_valid_o);

  assert_refill_completes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_we_o && mem_ready_i) |=> cpu_ready_o);

  assert_wb_then_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o && mem_ready_i) |=>
      (mem_valid_o && !mem_we_o &&
       mem_addr_o[OFF_W +: IDX_W] == $past(mem_addr_o[OFF_W +: IDX_W])));

  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_we_o) && $stable(mem_addr_o)));

  assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o |=> !cpu_ready_o);
endmodule

bind wb_cache_ctrl wb_cache_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W),
  .IDX_W  (IDX_W)
) u_chk (.*);

// File: tb/wb_cache_ctrl_test.sv
`timescale 1ns/1ps
module wb_cache_ctrl_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cpu_valid_i = 1'b0;
  logic         cpu_we_i = 1'b0;
  logic [31:0]  cpu_addr_i = '0;
  logic [31:0]  cpu_wdata_i = '0;
  logic [31:0]  cpu_rdata_o;
  logic         cpu_ready_o;
  logic         mem_valid_o;
  logic         mem_we_o;
  logic [31:0]  mem_addr_o;
  logic [127:0] mem_wdata_o;
  logic [127:0] mem_rdata_i = '0;
  logic         mem_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int mem_lat = 2;

  localparam logic [31:0] D1 = 32'hDEAD_0001;
  localparam logic [31:0] D2 = 32'hBEEF_0002;

  always #2.5 clk_i = ~clk_i;

  wb_cache_ctrl uut (.*);

  logic [127:0] mem_q [logic [31:0]];
  logic         op_we [$];
  logic [31:0]  op_addr [$];
  logic [127:0] op_data [$];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [127:0] pat_blk(input logic [31:0] a);
    logic [127:0] b;
    for (int k = 0; k < 4; k++) b[k*32 +: 32] = pat({a[31:4], 2'(k), 2'b00});
    return b;
  endfunction

  // memory model: answers mem_lat cycles after a request is seen
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk_i);
      if (mem_ready_i) begin
        mem_ready_i = 1'b0;
        cnt = 0;
      end else if (mem_valid_o) begin
        if (cnt >= mem_lat) begin
          mem_ready_i = 1'b1;
          cnt = 0;
          op_we.push_back(mem_we_o);
          op_addr.push_back(mem_addr_o);
          op_data.push_back(mem_wdata_o);
          if (mem_we_o) mem_q[mem_addr_o] = mem_wdata_o;
          else mem_rdata_i = mem_q.exists(mem_addr_o) ? mem_q[mem_addr_o] : pat_blk(mem_addr_o);
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    op_we.delete(); op_addr.delete(); op_data.delete();
    @(negedge clk_i);
    cpu_valid_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!cpu_ready_o && lat < 200);
    rd = cpu_rdata_o;
    cpu_valid_i = 1'b0;
    if (lat >= 200) chk(1'b0, "R8 access never completed", 128'(lat), 128'd0);
  endtask

  task automatic ops(input string req, input int n, input logic we0, input logic [31:0] a0,
                     input logic [127:0] d0, input logic we1, input logic [31:0] a1);
    chk(op_we.size() == n, {req, " transfer count"}, 128'(op_we.size()), 128'(n));
    if (n >= 1 && op_we.size() >= 1) begin
      chk(op_we[0] == we0 && op_addr[0] == a0, {req, " first transfer"},
          {op_we[0], op_addr[0]}, {we0, a0});
      if (we0) chk(op_data[0] == d0, {req, " written block"}, op_data[0], d0);
    end
    if (n >= 2 && op_we.size() >= 2)
      chk(op_we[1] == we1 && op_addr[1] == a1, {req, " second transfer"},
          {op_we[1], op_addr[1]}, {we1, a1});
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(!cpu_ready_o && !mem_valid_o, "R1 outputs idle after reset",
        {cpu_ready_o, mem_valid_o}, 128'd0);
  endtask

  task automatic t_cold_read();
    logic [31:0] rd; int lat;
    mem_lat = 2;
    access(1'b0, 32'h0000_1234, '0, rd, lat);
    ops("R1 R5 cold miss", 1, 1'b0, 32'h0000_1230, '0, 1'b0, '0);
    chk(rd == pat(32'h0000_1234), "R2 R5 word 1 of fetched block", rd, pat(32'h0000_1234));
    chk(lat == mem_lat + 3, "R8 clean miss stall", 128'(lat), 128'(mem_lat + 3));
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int lat;
    access(1'b0, 32'h0000_1238, '0, rd, lat);
    ops("R3 read hit", 0, 1'b0, '0, '0, 1'b0, '0);
    chk(lat == 1, "R3 hit latency", 128'(lat), 128'd1);
    chk(rd == pat(32'h0000_1238), "R3 hit data", rd, pat(32'h0000_1238));
    access(1'b0, 32'h0000_123B, '0, rd, lat);
    chk(rd == pat(32'h0000_1238), "R2 low address bits ignored", rd, pat(32'h0000_1238));
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int lat;
    access(1'b1, 32'h0000_1234, D1, rd, lat);
    ops("R4 write hit", 0, 1'b0, '0, '0, 1'b0, '0);
    chk(lat == 1, "R4 write hit latency", 128'(lat), 128'd1);
    access(1'b0, 32'h0000_1234, '0, rd, lat);
    chk(rd == D1, "R4 written word read back", rd, D1);
    access(1'b0, 32'h0000_1230, '0, rd, lat);
    chk(rd == pat(32'h0000_1230), "R4 neighbour word untouched", rd, pat(32'h0000_1230));
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int lat; logic [127:0] old;
    mem_lat = 6;
    old = pat_blk(32'h0000_1230);
    old[63:32] = D1;
    access(1'b0, 32'h0000_5230, '0, rd, lat);
    ops("R6 R9 dirty displacement", 2, 1'b1, 32'h0000_1230, old, 1'b0, 32'h0000_5230);
    chk(rd == pat(32'h0000_5230), "R6 new block data", rd, pat(32'h0000_5230));
    chk(lat == 2 * mem_lat + 5, "R8 dirty miss stall", 128'(lat), 128'(2 * mem_lat + 5));
    access(1'b0, 32'h0000_1234, '0, rd, lat);
    ops("R10 clean displacement", 1, 1'b0, 32'h0000_1230, '0, 1'b0, '0);
    chk(rd == D1, "R6 written-back word returned by memory", rd, D1);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int lat; logic [127:0] merged;
    mem_lat = 0;
    access(1'b1, 32'h0000_8040, D2, rd, lat);
    ops("R7 write miss fetch", 1, 1'b0, 32'h0000_8040, '0, 1'b0, '0);
    chk(lat == 3, "R8 write miss stall", 128'(lat), 128'd3);
    access(1'b0, 32'h0000_8044, '0, rd, lat);
    chk(rd == pat(32'h0000_8044) && lat == 1, "R7 fetched word kept", rd, pat(32'h0000_8044));
    access(1'b0, 32'h0000_8040, '0, rd, lat);
    chk(rd == D2, "R7 merged word", rd, D2);
    merged = pat_blk(32'h0000_8040);
    merged[31:0] = D2;
    mem_lat = 3;
    access(1'b0, 32'h0000_C040, '0, rd, lat);
    ops("R7 merged line is dirty", 2, 1'b1, 32'h0000_8040, merged, 1'b0, 32'h0000_C040);
  endtask

  task automatic t_coexist();
    logic [31:0] rd; int lat;
    access(1'b0, 32'h0000_1234, '0, rd, lat);
    chk(lat == 1 && rd == D1, "R9 index 0x123 still resident", {lat, rd}, {32'd1, D1});
    access(1'b0, 32'h0000_C040, '0, rd, lat);
    chk(lat == 1 && rd == pat(32'h0000_C040), "R9 index 0x004 still resident",
        {lat, rd}, {32'd1, pat(32'h0000_C040)});
    access(1'b0, 32'hFFFF_FFFC, '0, rd, lat);
    ops("R2 top index and tag", 1, 1'b0, 32'hFFFF_FFF0, '0, 1'b0, '0);
    chk(rd == pat(32'hFFFF_FFFC), "R2 word 3 lane", rd, pat(32'hFFFF_FFFC));
    access(1'b1, 32'h0000_3FF8, D1, rd, lat);
    ops("R10 R7 clean victim on write miss", 1, 1'b0, 32'h0000_3FF0, '0, 1'b0, '0);
  endtask

  task automatic t_rereset();
    logic [31:0] rd; int lat;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    mem_lat = 1;
    access(1'b0, 32'h0000_C040, '0, rd, lat);
    ops("R1 line forgotten after reset", 1, 1'b0, 32'h0000_C040, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_cold_read();
    t_read_hit();
    t_write_hit();
    t_dirty_evict();
    t_write_miss();
    t_coexist();
    t_rereset();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule